// File: doc/BRIEF.md
# Detour-Route Sequencer

This block is a six-state sequencer whose route depends on a remembered event. Normally it cycles A, B, C, D, E and back to A. In state C a single-bit abort input can send it back to A early. When that happens a registered detour flag is set. On the next pass the machine takes B to F instead of B to C. In F the flag is cleared and the machine returns to A, after which the normal route resumes.

The next-state logic is purely combinational and gives every signal a default, so no latch can be inferred. The flag lives in a D flip-flop with explicit set and clear terms. The current state code and the flag are brought out directly from their registers, so a system can watch the route the sequencer takes. Codes 6 and 7 are not used; if one ever appears, the machine recovers to A on the next clock.

Top module: `detour_fsm`

## Requirements
- R1: While the active-low asynchronous reset is low, the state output is A and the flag output is 0.
- R2: From state A the machine always moves to state B on the next clock, whatever the flag and the abort input are.
- R3: From state B with the flag clear, the next state is C.
- R4: From state B with the flag set, the next state is F.
- R5: In state C with abort at 1, the next state is A and the flag becomes 1 on the same clock.
- R6: In state C with abort at 0, the next state is D. D always goes to E, and E always goes to A.
- R7: State F always goes to A on the next clock and clears the flag on that clock.
- R8: In every case other than C with abort and F, the flag keeps its value. This includes abort asserted in states A, B, D and E.
- R9: The state output uses a 3-bit binary code: A=0, B=1, C=2, D=3, E=4, F=5. Codes 6 and 7 never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort_in | input | 1 | Abort condition; it only acts in state C |
| state_o | output | 3 | Current state code (A=0 through F=5) |
| flag_o | output | 1 | Registered detour flag |

## Verification
Every result is due one clock after its cause. Both the state and the flag are registered, so a transition decided by the state, the flag and abort in one cycle becomes visible right after the next rising edge. The bench drives abort on the falling edge and predicts the next state and flag from its own model of the route. It then samples at the following falling edge, half a period after the edge that commits the change. Random abort patterns with a fixed seed cover detours taken from many starting points. Directed sequences cover reset, the first aborted pass, abort pulses outside C, and a reset in the middle of a detour.

// File: rtl/detour_pkg.sv
package detour_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 3'd0,
        ST_B = 3'd1,
        ST_C = 3'd2,
        ST_D = 3'd3,
        ST_E = 3'd4,
        ST_F = 3'd5
    } route_state_t;
endpackage

// File: rtl/detour_next.sv
module detour_next
    import detour_pkg::*;
(
    input  route_state_t cur_i,
    input  logic         flag_i,
    input  logic         abort_i,
    output route_state_t nxt_o,
    output logic         set_o,
    output logic         clr_o
);
    always_comb begin
        // Every output gets a default first, so no path leaves one unassigned
        nxt_o = ST_A;
        set_o = 1'b0;
        clr_o = 1'b0;
        unique case (cur_i)
            ST_A: nxt_o = ST_B;
            ST_B: nxt_o = flag_i ? ST_F : ST_C;
            ST_C: begin
                if (abort_i) begin
                    nxt_o = ST_A;
                    set_o = 1'b1;
                end else begin
                    nxt_o = ST_D;
                end
            end
            ST_D: nxt_o = ST_E;
            ST_E: nxt_o = ST_A;
            ST_F: begin
                nxt_o = ST_A;
                clr_o = 1'b1;
            end
            default: nxt_o = ST_A;
        endcase
    end
endmodule

// File: rtl/detour_flag.sv
module detour_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && clr_i)); // R8
endmodule

// File: rtl/detour_fsm.sv
module detour_fsm
    import detour_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_in,
    output logic [STATE_W-1:0] state_o,
    output logic               flag_o
);
    route_state_t cur_q;
    route_state_t nxt_w;
    logic         set_w;
    logic         clr_w;
    logic         flag_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= ST_A;
        else
            cur_q <= nxt_w;
    end

    detour_next u_next (
        .cur_i   (cur_q),
        .flag_i  (flag_w),
        .abort_i (abort_in),
        .nxt_o   (nxt_w),
        .set_o   (set_w),
        .clr_o   (clr_w)
    );

    detour_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .flag_o (flag_w)
    );

    always_comb begin
        state_o = cur_q;
        flag_o  = flag_w;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (state_o == 3'd0 && !flag_o)); // R1
    AST_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd0 |=> state_o == 3'd1); // R2
    AST_B_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !flag_o) |=> state_o == 3'd2); // R3
    AST_B_DETOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && flag_o) |=> state_o == 3'd5); // R4
    AST_C_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && abort_in) |=> (state_o == 3'd0 && flag_o)); // R5
    AST_C_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && !abort_in) |=> state_o == 3'd3); // R6
    AST_E_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 |=> state_o == 3'd0); // R6
    AST_F_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd5 |=> (state_o == 3'd0 && !flag_o)); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(state_o == 3'd2 && abort_in) && state_o != 3'd5) |=> flag_o == $past(flag_o)); // R8
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5); // R9
endmodule

// File: tb/detour_fsm_test.sv
module detour_fsm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       abort_in = 1'b0;
    logic [2:0] state_o;
    logic       flag_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] m_state = 3'd0;
    logic       m_flag  = 1'b0;

    detour_fsm uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort_in (abort_in),
        .state_o  (state_o),
        .flag_o   (flag_o)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] pred_state(logic [2:0] s, logic f, logic ab);
        case (s)
            3'd0: return 3'd1;
            3'd1: return f ? 3'd5 : 3'd2;
            3'd2: return ab ? 3'd0 : 3'd3;
            3'd3: return 3'd4;
            3'd4: return 3'd0;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic pred_flag(logic [2:0] s, logic f, logic ab);
        if (s == 3'd2 && ab) return 1'b1;
        if (s == 3'd5) return 1'b0;
        return f;
    endfunction

    function automatic string req_of(logic [2:0] s, logic f, logic ab);
        case (s)
            3'd0: return ab ? "R2/R8" : "R2";
            3'd1: return f ? "R4" : (ab ? "R3/R8" : "R3");
            3'd2: return ab ? "R5" : "R6";
            3'd3: return ab ? "R6/R8" : "R6";
            3'd4: return ab ? "R6/R8" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [2:0] act_s, logic act_f,
                         logic [2:0] exp_s, logic exp_f);
        n_cmp++;
        if (act_s !== exp_s || act_f !== exp_f) begin
            n_bad++;
            $display("FAIL %s: state=%0d flag=%0b, expected state=%0d flag=%0b",
                     req, act_s, act_f, exp_s, exp_f);
        end
    endtask

    task automatic step(logic ab);
        logic [2:0] es;
        logic       ef;
        string      rq;
        abort_in = ab;
        es = pred_state(m_state, m_flag, ab);
        ef = pred_flag(m_state, m_flag, ab);
        rq = req_of(m_state, m_flag, ab);
        @(posedge clk);
        @(negedge clk);
        check(rq, state_o, flag_o, es, ef);
        n_cmp++;
        if (state_o > 3'd5) begin
            n_bad++;
            $display("FAIL R9: state=%0d, expected a code of 5 or less", state_o);
        end
        m_state = es;
        m_flag  = ef;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #3;
        check("R1", state_o, flag_o, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        m_state = 3'd0;
        m_flag  = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        #5;
        check("R1", state_o, flag_o, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R6: one plain lap A B C D E A
        for (int i = 0; i < 5; i++) step(1'b0);
        check("R9", state_o, flag_o, 3'd0, 1'b0);

        // R5 then R4 R7: abort in C, detour through F
        step(1'b0); step(1'b0); step(1'b1);
        check("R5", state_o, flag_o, 3'd0, 1'b1);
        step(1'b1); step(1'b1);
        check("R4", state_o, flag_o, 3'd5, 1'b1);
        step(1'b1);
        check("R7", state_o, flag_o, 3'd0, 1'b0);

        // R8: abort held high outside C does not move the flag
        step(1'b1); step(1'b0); step(1'b0); step(1'b1); step(1'b1);
        check("R8", state_o, flag_o, 3'd0, 1'b0);

        // R1: reset in the middle of a detour
        step(1'b0); step(1'b0); step(1'b1); step(1'b0);
        do_reset();
        step(1'b0);
        check("R1", state_o, flag_o, 3'd1, 1'b0);
        step(1'b0);

        // Random abort patterns
        for (int i = 0; i < 400; i++) step(($urandom % 3) == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule